// File: doc/BRIEF.md
# Four-Phase Bundled-Data Pipeline Stage

This block is one stage of a single-rail pipeline whose channels carry a data bundle together with a request wire and an acknowledge wire. A token arrives when the upstream sender raises its request while holding the data steady. The stage then opens its capture latch, runs the data through its combinational function, and times the evaluation with a matched delay instead of watching the data. When that delay expires, the result is offered downstream on the outgoing request. Only after the downstream receiver acknowledges does the stage acknowledge upstream. The return-to-zero half follows the same causal chain with falling edges.

The block is modelled synchronously. The matched delay is a count of clock cycles, set by a parameter. The latch is a register that follows its input while enabled and holds its value otherwise. The combinational function adds a constant to the incoming word, modulo the word width. Both the constant and the width are parameters. A sticky protocol-error flag records an upstream request that is withdrawn before the stage has acknowledged it.

Top module: `bd_pipe_stage`

## Requirements
- R1: While reset is asserted, and after it is released, `up_ack`, `dn_req`, `proto_err` and `dn_data` are 0 until a token arrives. The reset is asynchronous and active low, and it is released through a two-stage synchronizer.
- R2: Take edge 0 as the first rising clock edge at which `up_req` is sampled high in idle. `dn_req` stays low through edge DELAY and is high after edge DELAY+1. It never rises unless the matched-delay done signal is already high.
- R3: While `dn_req` is high, `dn_data` equals (`up_data` + ADDEND) mod 2^W, using the value `up_data` held during evaluation. It does not change while `dn_req` stays high.
- R4: `up_ack` rises only after `dn_ack` is sampled high, and it is high after the first edge at which `dn_ack` is sampled high in the offering state. It stays low while `dn_ack` is low.
- R5: Take edge F0 as the edge at which `up_req` is sampled low after `up_ack` is high. `dn_req` stays high after edges F0 and F0+1 and is low after edge F0+2, once done has fallen. `up_ack` stays high until `dn_ack` is sampled low, and it is low after that edge.
- R6: Changes on `up_data` while the stage is idle, or after `up_ack` has risen, do not alter `dn_data`.
- R7: If `up_req` is sampled low while the stage is evaluating or offering, before `up_ack` has risen, `proto_err` is 1 after that edge. It stays 1 until reset.
- R8: Tokens may follow each other back to back. Each token goes through the full four-phase sequence, and a correct sequence leaves `proto_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream request |
| up_ack | output | 1 | Upstream acknowledge |
| up_data | input | W | Upstream data bundle |
| dn_req | output | 1 | Downstream request |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_data | output | W | Downstream data bundle |
| proto_err | output | 1 | Sticky flag for an early request withdrawal |

## Verification
Tokens are drawn from a table. The table covers zero, all-ones (which wraps the adder), alternating bit patterns and the sign-boundary values. Each token is paired with a different downstream acknowledge latency, so a correct sum is distinguished from a stale or unlatched one, and an early upstream acknowledge is distinguished from one that waits. Every token also changes `up_data` after `up_ack` rises and while idle, which separates a closed latch from a transparent one. A directed early withdrawal of `up_req` shows whether the error flag is set, whether it is sticky, and whether only reset clears it.

// File: rtl/bd_stage_pkg.sv
package bd_stage_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_EVAL = 3'd1,
    ST_SEND = 3'd2,
    ST_ACK  = 3'd3,
    ST_DROP = 3'd4,
    ST_REL  = 3'd5
  } stage_state_e;
endpackage

// File: rtl/bd_match_delay.sv
module bd_match_delay #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    if (start && !done_q) cnt_d = cnt_q + 1'b1;
    else if (!start)      cnt_d = '0;
    done_d = start && (done_q || (cnt_q == LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  // R2: done never rises without start being held
  a_r2_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start));
endmodule

// File: rtl/bd_data_latch.sv
module bd_data_latch #(
  parameter int          W      = 8,
  parameter logic [W-1:0] ADDEND = W'(19)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] f_val;
  logic [W-1:0] q_r;

  always_comb f_val = d + ADDEND;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= f_val;
  end

  assign q = q_r;

  // R6: closed latch holds its value
  a_r6_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> $stable(q));
endmodule

// File: rtl/bd_stage_ctrl.sv
module bd_stage_ctrl
  import bd_stage_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_req,
  input  logic dn_ack,
  input  logic done,
  output logic start,
  output logic dn_req,
  output logic up_ack,
  output logic latch_en,
  output logic proto_err
);
  stage_state_e st_q, st_d;
  logic         err_q, err_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (up_req)  st_d = ST_EVAL;
      ST_EVAL: if (done)    st_d = ST_SEND;
      ST_SEND: if (dn_ack)  st_d = ST_ACK;
      ST_ACK:  if (!up_req) st_d = ST_DROP;
      ST_DROP: if (!done)   st_d = ST_REL;
      ST_REL:  if (!dn_ack) st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
    err_d = err_q || (((st_q == ST_EVAL) || (st_q == ST_SEND)) && !up_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign start     = (st_q == ST_EVAL) || (st_q == ST_SEND) || (st_q == ST_ACK);
  assign dn_req    = (st_q == ST_SEND) || (st_q == ST_ACK)  || (st_q == ST_DROP);
  assign up_ack    = (st_q == ST_ACK)  || (st_q == ST_DROP) || (st_q == ST_REL);
  assign latch_en  = (st_q == ST_EVAL);
  assign proto_err = err_q;

  // R4: upstream acknowledge follows the downstream one
  a_r4_ack_after_dn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ack) |-> dn_ack);
  // R5: downstream request falls only after done has fallen
  a_r5_req_fall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_req) |-> !done);
  // R5: upstream acknowledge falls only after downstream acknowledge is low
  a_r5_ack_fall_after_dn: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_ack) |-> (!dn_ack && !dn_req));
  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err);
endmodule

// File: rtl/bd_pipe_stage.sv
module bd_pipe_stage #(
  parameter int           W      = 8,
  parameter int           DELAY  = 3,
  parameter logic [W-1:0] ADDEND = W'(19)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_req,
  output logic         up_ack,
  input  logic [W-1:0] up_data,
  output logic         dn_req,
  input  logic         dn_ack,
  output logic [W-1:0] dn_data,
  output logic         proto_err
);
  logic [1:0] rst_pipe;
  logic       rst_q;
  logic       start, done, latch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  bd_stage_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_q), .up_req(up_req), .dn_ack(dn_ack), .done(done),
    .start(start), .dn_req(dn_req), .up_ack(up_ack), .latch_en(latch_en),
    .proto_err(proto_err)
  );

  bd_match_delay #(.DELAY(DELAY)) u_delay (
    .clk(clk), .rst_n(rst_q), .start(start), .done(done)
  );

  bd_data_latch #(.W(W), .ADDEND(ADDEND)) u_latch (
    .clk(clk), .rst_n(rst_q), .en(latch_en), .d(up_data), .q(dn_data)
  );

  // R2: request offered downstream only once the matched delay is done
  a_r2_req_after_done: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(dn_req) |-> done);
  // R3: offered data holds while request is high
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (dn_req && $past(dn_req)) |-> $stable(dn_data));
endmodule

// File: tb/bd_pipe_stage_bench.sv
module bd_pipe_stage_bench;
  localparam int           W      = 8;
  localparam int           DELAY  = 3;
  localparam logic [W-1:0] ADDEND = 8'h13;
  localparam int           NV     = 6;
  // {ack latency, data}
  localparam logic [11:0] VEC [NV] = '{
    {4'd0, 8'h00}, {4'd2, 8'hFF}, {4'd1, 8'h5A},
    {4'd5, 8'hA5}, {4'd0, 8'h7F}, {4'd3, 8'h80}
  };

  logic         clk = 1'b0;
  logic         rst_n, up_req, dn_ack;
  logic [W-1:0] up_data;
  logic         up_ack, dn_req, proto_err;
  logic [W-1:0] dn_data;
  int           n_run = 0;
  int           n_fail = 0;
  bit           finished = 1'b0;

  always #5 clk = ~clk;

  bd_pipe_stage #(.W(W), .DELAY(DELAY), .ADDEND(ADDEND)) u_bd_pipe_stage (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack), .up_data(up_data),
    .dn_req(dn_req), .dn_ack(dn_ack), .dn_data(dn_data), .proto_err(proto_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nstep(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic token(input logic [W-1:0] d, input int ackw);
    logic [W-1:0] exp;
    exp = d + ADDEND;
    up_data = d; up_req = 1'b1;
    nstep(DELAY + 1);
    check(dn_req == 1'b0, "R2 req low before delay", dn_req, 0);
    nstep(1);
    check(dn_req == 1'b1, "R2 req high after delay", dn_req, 1);
    check(dn_data == exp, "R3 sum", dn_data, exp);
    nstep(ackw);
    check(up_ack == 1'b0, "R4 no early ack", up_ack, 0);
    dn_ack = 1'b1;
    nstep(1);
    check(up_ack == 1'b1, "R4 ack after dn ack", up_ack, 1);
    up_data = ~d; up_req = 1'b0;
    nstep(2);
    check(dn_req == 1'b1, "R5 req held F0+1", dn_req, 1);
    nstep(1);
    check(dn_req == 1'b0, "R5 req low F0+2", dn_req, 0);
    check(up_ack == 1'b1, "R5 ack held", up_ack, 1);
    check(dn_data == exp, "R6 data after ack", dn_data, exp);
    dn_ack = 1'b0;
    nstep(1);
    check(up_ack == 1'b0, "R5 ack low", up_ack, 0);
    up_data = d ^ 8'h3C;
    nstep(2);
    check(dn_data == exp, "R6 idle glitch ignored", dn_data, exp);
  endtask

  initial begin
    rst_n = 1'b0; up_req = 1'b0; dn_ack = 1'b0; up_data = '0;
    nstep(3);
    check(up_ack == 0 && dn_req == 0 && proto_err == 0 && dn_data == 0,
          "R1 reset state", {up_ack, dn_req, proto_err}, 0);
    rst_n = 1'b1;
    nstep(4);
    check(up_ack == 0 && dn_req == 0 && dn_data == 0, "R1 after release",
          {up_ack, dn_req}, 0);
    for (int v = 0; v < NV; v++) token(VEC[v][7:0], int'(VEC[v][11:8]));
    check(proto_err == 1'b0, "R8 clean sequence no error", proto_err, 0);
    // R8: two tokens back to back with no gap
    token(8'h01, 0);
    token(8'hEC, 1);
    // R7: early withdrawal
    up_data = 8'h22; up_req = 1'b1;
    nstep(1);
    check(proto_err == 1'b0, "R7 no error yet", proto_err, 0);
    up_req = 1'b0;
    nstep(1);
    check(proto_err == 1'b1, "R7 error raised", proto_err, 1);
    nstep(DELAY + 1);
    dn_ack = 1'b1;
    nstep(6);
    dn_ack = 1'b0;
    nstep(3);
    check(proto_err == 1'b1, "R7 error sticky", proto_err, 1);
    check(up_ack == 1'b0 && dn_req == 1'b0, "R7 returned idle", {up_ack, dn_req}, 0);
    rst_n = 1'b0;
    nstep(1);
    check(proto_err == 1'b0, "R7 R1 cleared by reset", proto_err, 0);
    rst_n = 1'b1;
    nstep(4);
    token(8'h33, 1);
    check(proto_err == 1'b0, "R8 token after reset", proto_err, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule